// File: doc/BRIEF.md
# Core Interrupt Pin Qualifier

This block sits between six asynchronous interrupt and control pins of a processor core and the core's exception logic. Each pin is brought into the clock domain through a two-flop synchroniser. Its synchronised level is then compared with a registered copy of the last level the block acted on. A sample that equals the stored level produces no event. A sample that differs produces a rise or a fall event, and each pin turns that event into an action according to its own polarity and sensitivity.

Four sources keep a bit in a pending vector: external interrupt, system management interrupt, machine check and soft reset. A single registered interrupt-request output is high whenever any pending bit is set. Two pins do not keep a pending bit. The checkstop pin stops the core. The hard reset pin asks for a core reset. A one-hot acknowledge input clears the edge-triggered pending bit. The level-following bits do not respond to it.

Top module: `core_pin_irq_ctrl`

## Requirements
- R1: After the synchronous reset, `pending_o`, `irq_o`, `halt_o` and `core_reset_o` are all 0.
- R2: A pin change presented before clock edge k shows its effect at the outputs after edge k+2, and not earlier. The path is two synchroniser stages plus one output register.
- R3: Pin bit 0 (external interrupt, active high, level) drives pending bit 0. A rise sets the bit and a fall clears it.
- R4: Pin bit 1 (system management interrupt, active high, level) drives pending bit 1 in the same way.
- R5: Pin bit 2 (machine check) sets pending bit 2 only on a falling edge, that is a stored 1 followed by a sampled 0. A rise neither sets nor clears the bit.
- R6: `ack_i` bit 2 clears pending bit 2. When an acknowledge and a new machine-check fall arrive in the same cycle, the bit stays set. Acknowledge bits 0, 1 and 3 have no effect.
- R7: Pin bit 5 (soft reset request, active high, level) drives pending bit 3. A rise sets the bit and a fall clears it.
- R8: A fall on pin bit 3 (checkstop, active low) sets `halt_o`. Only the block reset clears it. The pin returning high does not.
- R9: A fall on pin bit 4 (hard reset, active low) gives a one-cycle pulse on `core_reset_o`. Holding the pin low does not repeat the pulse.
- R10: `irq_o` is 1 exactly when `pending_o` is nonzero.
- R11: The synchroniser and the stored last levels reset to the idle level of each pin: 0 for bits 0, 1 and 5, and 1 for bits 2, 3 and 4. Pins held at idle across reset release therefore cause no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | NUM_PINS (6) | Raw asynchronous pins; bit order as in R3 to R9 |
| ack_i | input | NUM_PEND (4) | One-hot acknowledge; only bit 2 acts |
| pending_o | output | NUM_PEND (4) | Pending vector: ext, smi, machine check, soft reset |
| irq_o | output | 1 | Interrupt request, high while any pending bit is set |
| halt_o | output | 1 | Sticky core halt from checkstop |
| core_reset_o | output | 1 | One-cycle core reset request |

## Verification
The bench holds the machine-check pin low across an acknowledge that arrives in the same cycle as the fall. A design that lets the clear win would lose that event. It releases the checkstop pin after it has been asserted, and holds the hard reset pin low for many cycles. A design that tracks levels instead of transitions would drop the halt, or would pulse the core reset again and again. It acknowledges the level-following sources while they are pending, and counts the cycles from a pin change to the output. This catches a stage missing from the synchroniser and an acknowledge that reaches the wrong bits. Random pin patterns, with settling time after each, are checked against a bench model of the pending vector, the halt flag and the request output.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int NUM_PINS = 6;
  localparam int NUM_PEND = 4;

  // pin positions
  localparam int PIN_EXT   = 0;
  localparam int PIN_SMI   = 1;
  localparam int PIN_MCHK  = 2;
  localparam int PIN_CSTOP = 3;
  localparam int PIN_HRST  = 4;
  localparam int PIN_SRST  = 5;

  // pending positions
  localparam int PND_EXT  = 0;
  localparam int PND_SMI  = 1;
  localparam int PND_MCHK = 2;
  localparam int PND_SRST = 3;

  // inactive level of each pin: 1 for the active-low and falling-edge pins
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 6'b011100;

  typedef struct packed {
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;
  } pin_evt_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int                 W      = 6,
  parameter int                 STAGES = 2,
  parameter logic [W-1:0]       IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl_i,
  output pin_evt_t            evt_o
);
  logic [NUM_PINS-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= PIN_IDLE;
    else     last_q <= lvl_i;
  end

  // a sample equal to the stored level yields neither event
  always_comb begin
    evt_o.rise = lvl_i & ~last_q;
    evt_o.fall = ~lvl_i & last_q;
  end

  // R11: after an event the stored level has moved, so the same event cannot repeat
  a_r11_no_repeat_rise: assert property (@(posedge clk) disable iff (rst)
    (|evt_o.rise) |=> ((evt_o.rise & $past(evt_o.rise)) == '0));
  a_r11_no_repeat_fall: assert property (@(posedge clk) disable iff (rst)
    (|evt_o.fall) |=> ((evt_o.fall & $past(evt_o.fall)) == '0));
endmodule

// File: rtl/pending_ctrl.sv
module pending_ctrl
  import pin_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  pin_evt_t            evt_i,
  input  logic [NUM_PEND-1:0] ack_i,
  output logic [NUM_PEND-1:0] pend_o,
  output logic                irq_o
);
  logic [NUM_PEND-1:0] pend_q, pend_nxt;
  logic                irq_q;

  always_comb begin
    pend_nxt = pend_q;
    // level-following sources
    if (evt_i.rise[PIN_EXT])  pend_nxt[PND_EXT]  = 1'b1;
    if (evt_i.fall[PIN_EXT])  pend_nxt[PND_EXT]  = 1'b0;
    if (evt_i.rise[PIN_SMI])  pend_nxt[PND_SMI]  = 1'b1;
    if (evt_i.fall[PIN_SMI])  pend_nxt[PND_SMI]  = 1'b0;
    if (evt_i.rise[PIN_SRST]) pend_nxt[PND_SRST] = 1'b1;
    if (evt_i.fall[PIN_SRST]) pend_nxt[PND_SRST] = 1'b0;
    // sticky edge source: acknowledge first, a new fall overrides it
    if (ack_i[PND_MCHK])      pend_nxt[PND_MCHK] = 1'b0;
    if (evt_i.fall[PIN_MCHK]) pend_nxt[PND_MCHK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      irq_q  <= |pend_nxt;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R10: request output tracks the vector
  a_r10_irq_any: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q != '0));
  // R3: external interrupt rise is reflected next cycle
  a_r3_ext_rise: assert property (@(posedge clk) disable iff (rst)
    evt_i.rise[PIN_EXT] |=> pend_q[PND_EXT]);
  // R5: machine check stays pending until acknowledged
  a_r5_mchk_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend_q[PND_MCHK] && !ack_i[PND_MCHK]) |=> pend_q[PND_MCHK]);
  // R5: nothing but a fall sets machine check
  a_r5_mchk_fall_only: assert property (@(posedge clk) disable iff (rst)
    (!pend_q[PND_MCHK] && !evt_i.fall[PIN_MCHK]) |=> !pend_q[PND_MCHK]);
  // R6: without a pin event the level bits hold, whatever the acknowledge
  a_r6_ack_level_ignored: assert property (@(posedge clk) disable iff (rst)
    (!evt_i.rise[PIN_SMI] && !evt_i.fall[PIN_SMI]) |=> $stable(pend_q[PND_SMI]));
  // R7: soft reset fall clears its bit
  a_r7_srst_fall: assert property (@(posedge clk) disable iff (rst)
    evt_i.fall[PIN_SRST] |=> !pend_q[PND_SRST]);
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import pin_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_evt_t evt_i,
  output logic     halt_o,
  output logic     core_reset_o
);
  logic halt_q, crst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      crst_q <= 1'b0;
    end else begin
      if (evt_i.fall[PIN_CSTOP]) halt_q <= 1'b1;
      crst_q <= evt_i.fall[PIN_HRST];
    end
  end

  assign halt_o       = halt_q;
  assign core_reset_o = crst_q;

  // R8: halt holds until block reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);
  // R9: reset request never lasts two cycles
  a_r9_reset_pulse: assert property (@(posedge clk) disable iff (rst)
    crst_q |=> !crst_q);
endmodule

// File: rtl/core_pin_irq_ctrl.sv
module core_pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PEND-1:0] ack_i,
  output logic [NUM_PEND-1:0] pending_o,
  output logic                irq_o,
  output logic                halt_o,
  output logic                core_reset_o
);
  logic [NUM_PINS-1:0] lvl;
  pin_evt_t            evt;

  pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk (clk), .rst (rst), .d_i (pins_i), .q_o (lvl)
  );

  pin_event_detect u_evt (
    .clk (clk), .rst (rst), .lvl_i (lvl), .evt_o (evt)
  );

  pending_ctrl u_pend (
    .clk (clk), .rst (rst), .evt_i (evt), .ack_i (ack_i),
    .pend_o (pending_o), .irq_o (irq_o)
  );

  core_ctrl u_core (
    .clk (clk), .rst (rst), .evt_i (evt),
    .halt_o (halt_o), .core_reset_o (core_reset_o)
  );

  // R1: outputs are quiet in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pending_o == '0 && !irq_o && !halt_o && !core_reset_o));
endmodule

// File: tb/core_pin_irq_ctrl_tb_top.sv
module core_pin_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] pins;
  logic [3:0] ack;
  logic [3:0] pending;
  logic       irq, halt, crst;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  core_pin_irq_ctrl dut_i (
    .clk (clk), .rst (rst), .pins_i (pins), .ack_i (ack),
    .pending_o (pending), .irq_o (irq), .halt_o (halt), .core_reset_o (crst)
  );

  localparam logic [5:0] IDLE = 6'b011100;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next pending vector from old and new settled pin levels
  function automatic logic [3:0] f_pend(logic [3:0] p, logic [5:0] o, logic [5:0] n);
    logic [3:0] r = p;
    r[0] = n[0];
    r[1] = n[1];
    r[3] = n[5];
    if (o[2] && !n[2]) r[2] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] f_ack(logic [3:0] p, logic [3:0] a);
    return a[2] ? (p & 4'b1011) : p;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] ep;
    logic [5:0] old;
    logic       eh;
    void'($urandom(32'h5eed_0042));
    pins = IDLE;
    ack  = '0;
    do_reset();

    // R1 / R11 reset state with idle pins
    chk("R1 pending", pending, 4'h0);
    chk("R1 irq", irq, 1'b0);
    settle();
    chk("R11 idle no event pending", pending, 4'h0);
    chk("R11 idle no halt", halt, 1'b0);
    chk("R1 core_reset", crst, 1'b0);

    // R2 latency and R3 external interrupt rise
    pins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet after two edges", pending[0], 1'b0);
    @(negedge clk);
    chk("R2/R3 ext set after three edges", pending[0], 1'b1);
    chk("R10 irq with ext", irq, 1'b1);
    // R6 ack on level bit ignored
    ack = 4'b0001; @(negedge clk); ack = '0; @(negedge clk);
    chk("R6 ack ext ignored", pending[0], 1'b1);
    pins[0] = 1'b0; settle();
    chk("R3 ext cleared on fall", pending[0], 1'b0);
    chk("R10 irq drops when empty", irq, 1'b0);

    // R4 smi
    pins[1] = 1'b1; settle();
    chk("R4 smi set", pending, 4'b0010);
    ack = 4'b0010; @(negedge clk); ack = '0; @(negedge clk);
    chk("R6 ack smi ignored", pending[1], 1'b1);
    pins[1] = 1'b0; settle();
    chk("R4 smi cleared", pending[1], 1'b0);

    // R7 soft reset
    pins[5] = 1'b1; settle();
    chk("R7 srst set", pending, 4'b1000);
    ack = 4'b1000; @(negedge clk); ack = '0; @(negedge clk);
    chk("R6 ack srst ignored", pending[3], 1'b1);
    pins[5] = 1'b0; settle();
    chk("R7 srst cleared", pending[3], 1'b0);

    // R5 machine check: fall sets, rise keeps
    pins[2] = 1'b0; settle();
    chk("R5 mchk fall sets", pending, 4'b0100);
    pins[2] = 1'b1; settle();
    chk("R5 mchk rise keeps", pending[2], 1'b1);
    chk("R10 irq with mchk", irq, 1'b1);
    ack = 4'b0100; @(negedge clk); ack = '0;
    chk("R6 ack clears mchk", pending[2], 1'b0);
    chk("R10 irq after ack", irq, 1'b0);
    settle();
    chk("R5 rise alone does not set", pending[2], 1'b0);

    // R6 fall and ack in the same cycle: set wins
    pins[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    ack = 4'b0100;
    @(negedge clk);
    ack = '0;
    chk("R6 fall beats same-cycle ack", pending[2], 1'b1);
    pins[2] = 1'b1; settle();
    ack = 4'b0100; @(negedge clk); ack = '0;

    // R9 hard reset pulse
    pins[4] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 no pulse early", crst, 1'b0);
    @(negedge clk);
    chk("R9 pulse", crst, 1'b1);
    @(negedge clk);
    chk("R9 pulse one cycle", crst, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 held low no repeat", crst, 1'b0);
    pins[4] = 1'b1; settle();
    chk("R9 release no pulse", crst, 1'b0);

    // R8 checkstop
    pins[3] = 1'b0; settle();
    chk("R8 halt set", halt, 1'b1);
    pins[3] = 1'b1; settle();
    chk("R8 halt persists after release", halt, 1'b1);
    do_reset();
    chk("R8/R1 reset clears halt", halt, 1'b0);
    settle();

    // random patterns against the model
    ep = pending;
    old = pins;
    eh = 1'b0;
    for (int i = 0; i < 80; i++) begin
      logic [5:0] nw;
      logic [3:0] a;
      nw = 6'($urandom);
      ep = f_pend(ep, old, nw);
      if (old[3] && !nw[3]) eh = 1'b1;
      pins = nw;
      settle();
      chk("R3/R4/R5/R7 random pending", pending, ep);
      chk("R10 random irq", irq, ep != 4'h0);
      chk("R8 random halt", halt, eh);
      a = 4'($urandom);
      ack = a; @(negedge clk); ack = '0;
      ep = f_ack(ep, a);
      chk("R6 random ack", pending, ep);
      old = nw;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule